// File: doc/BRIEF.md
# Converter Conversion Control Sequencer

This block is the digital control core of a 12-bit successive-approximation converter. A host writes an 8-bit control byte through an active-low chip-select and write strobe. The byte sets the power state, the conversion clock source, the acquisition style, the input configuration (single-ended or pseudo-differential, unipolar or bipolar) and the channel address. The sequencer then runs an acquisition phase and a 13-cycle conversion phase. When a valid result is ready, it pulls an active-low interrupt low.

Acquisition can be self-timed: a write with the acquisition-mode bit clear gives three cycles of acquisition, and conversion follows on its own. It can also be host-timed: a write with the bit set opens an acquisition of unbounded length, and a later write with the bit clear closes it and starts conversion. A write that arrives during a conversion abandons that conversion and restarts acquisition. A behavioural comparator stub stands in for the analog path. It samples a test word when conversion starts and resolves it one bit per cycle, most significant bit first.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `irq_n` is 1, `pwr_state` is 00 (full power-down), `clk_ext` is 0 (internal clock), `corrupt` is 0 and `result` is 0.
- R2: On a write, the control byte is decoded as follows, and `acq_ext`, `single_ended`, `unipolar` and `chan_sel` follow it from the cycle after the write completes:
  - bits 7:6 are the power field, and `pwr_state` becomes 10 (normal) for 1x;
  - bit 6 of a 1x power field sets `clk_ext`;
  - bit 5 is the acquisition mode (1 = host-timed);
  - bit 4 is single-ended (1) or pseudo-differential (0);
  - bit 3 is unipolar (1) or bipolar (0);
  - bits 2:0 are the channel address.
- R3: A power field of 00 gives `pwr_state` 00 and a power field of 01 gives 01. In both cases `clk_ext` keeps its previous value.
- R4: A write with bit 5 clear gives 3 cycles of acquisition and then 13 cycles of conversion. `irq_n` falls at the 16th rising clock edge after the edge at which the write strobe rises with chip-select low.
- R5: A write with bit 5 set starts no conversion, however long it lasts. A following write with bit 5 clear starts conversion at the rising edge of its write strobe, and `irq_n` falls 13 clock edges later.
- R6: At the end of a conversion, `result` holds the value `sar_word` had when the conversion started.
- R7: A write during a conversion abandons it and restarts acquisition. `result` keeps its previous value until a later conversion completes.
- R8: When the second write of a host-timed acquisition differs from the first in bits 4:0, `corrupt` goes to 1 from that write on. A change in the power field alone leaves `corrupt` at 0. Every write that does not end a host-timed acquisition clears `corrupt`.
- R9: `irq_n` returns to 1 on a read cycle (`rd_n` falling while `cs_n` is low) and on any completed write.
- R10: A read cycle while `pwr_state` is 00 or 01 sets `pwr_state` to 10 and leaves `clk_ext` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; the control byte is taken on its rising edge |
| rd_n | input | 1 | Read strobe, active low; a falling edge is a read cycle |
| din | input | 8 | Control byte |
| sar_word | input | 12 | Test value that the comparator stub converts |
| pwr_state | output | 2 | 00 full power-down, 01 standby, 10 normal |
| clk_ext | output | 1 | 1 when the external conversion clock is selected |
| acq_ext | output | 1 | 1 when host-timed acquisition is selected |
| single_ended | output | 1 | Input configuration flag |
| unipolar | output | 1 | Input range flag |
| chan_sel | output | 3 | Channel address |
| result | output | 12 | Last completed conversion result |
| irq_n | output | 1 | Active-low result-ready interrupt |
| corrupt | output | 1 | Host-timed acquisition ended with changed configuration bits |

## Verification
The hardest situation to reach is a write that lands in the middle of a running conversion. It has to hit a window of 13 cycles that opens only after acquisition has ended. The bench counts clock edges from the commit edge of the first write and places the second write's strobe inside that window. It also changes `sar_word` in between, so the result that survives the abort can be told apart from the result of the next conversion. Host-timed acquisition needs two writes with chosen differences in bits 4:0 and in the power field. The bench pairs them on purpose to separate a corrupting change from a permitted one.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'b00,
    PH_ACQ_INT = 2'b01,
    PH_ACQ_EXT = 2'b10,
    PH_CONV    = 2'b11
  } phase_t;

  typedef enum logic [1:0] {
    PWR_FULL = 2'b00,
    PWR_STBY = 2'b01,
    PWR_NORM = 2'b10
  } pwr_t;

  localparam int CTRL_W    = 8;
  localparam int CHAN_W    = 3;
  localparam int BIT_PWRHI = 7;
  localparam int BIT_PWRLO = 6;
  localparam int BIT_ACQ   = 5;
  localparam int BIT_SGL   = 4;
  localparam int BIT_UNI   = 3;
endpackage

// File: rtl/adc_ctl_decode.sv
module adc_ctl_decode
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [CTRL_W-1:0] din,
  output logic              wr_commit,
  output logic              rd_access,
  output pwr_t              pwr_state,
  output logic              clk_ext,
  output logic              acq_ext,
  output logic              single_ended,
  output logic              unipolar,
  output logic [CHAN_W-1:0] chan_sel
);
  logic wr_n_q;
  logic rd_n_q;

  assign wr_commit = !wr_n_q && wr_n && !cs_n;
  assign rd_access = rd_n_q && !rd_n && !cs_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_n_q <= 1'b1;
      rd_n_q <= 1'b1;
    end else begin
      wr_n_q <= wr_n;
      rd_n_q <= rd_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_state    <= PWR_FULL;
      clk_ext      <= 1'b0;
      acq_ext      <= 1'b0;
      single_ended <= 1'b0;
      unipolar     <= 1'b0;
      chan_sel     <= '0;
    end else if (wr_commit) begin
      if (din[BIT_PWRHI]) begin
        pwr_state <= PWR_NORM;
        clk_ext   <= din[BIT_PWRLO];
      end else begin
        pwr_state <= din[BIT_PWRLO] ? PWR_STBY : PWR_FULL;
      end
      acq_ext      <= din[BIT_ACQ];
      single_ended <= din[BIT_SGL];
      unipolar     <= din[BIT_UNI];
      chan_sel     <= din[CHAN_W-1:0];
    end else if (rd_access && pwr_state != PWR_NORM) begin
      pwr_state <= PWR_NORM;
    end
  end
endmodule

// File: rtl/adc_phase_timer.sv
module adc_phase_timer
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int ACQ_CYCLES  = 3,
  parameter int CONV_CYCLES = DATA_W + 1
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   wr_commit,
  input  logic   rd_access,
  input  logic   acqmod,
  input  logic   cfg_match,
  output phase_t phase,
  output logic   sar_load,
  output logic   sar_step,
  output logic   conv_done,
  output logic   irq_n,
  output logic   corrupt
);
  localparam int MAXC  = (ACQ_CYCLES > CONV_CYCLES) ? ACQ_CYCLES : CONV_CYCLES;
  localparam int CNT_W = $clog2(MAXC) + 1;
  localparam logic [CNT_W-1:0] ACQ_LAST  = CNT_W'(ACQ_CYCLES - 1);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYCLES - 1);
  localparam logic [CNT_W-1:0] STEP_END  = CNT_W'(DATA_W);

  logic [CNT_W-1:0] cnt;
  logic             ends_ext;

  assign ends_ext = wr_commit && phase == PH_ACQ_EXT && !acqmod;

  always_comb begin
    sar_load = 1'b0;
    if (wr_commit) sar_load = ends_ext;
    else if (phase == PH_ACQ_INT && cnt == ACQ_LAST) sar_load = 1'b1;
  end

  assign conv_done = !wr_commit && phase == PH_CONV && cnt == CONV_LAST;
  assign sar_step  = !wr_commit && phase == PH_CONV && cnt < STEP_END;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      irq_n   <= 1'b1;
      corrupt <= 1'b0;
    end else if (wr_commit) begin
      irq_n <= 1'b1;
      cnt   <= '0;
      if (ends_ext) begin
        phase   <= PH_CONV;
        corrupt <= !cfg_match;
      end else begin
        phase   <= acqmod ? PH_ACQ_EXT : PH_ACQ_INT;
        corrupt <= 1'b0;
      end
    end else begin
      if (rd_access) irq_n <= 1'b1;
      case (phase)
        PH_ACQ_INT: begin
          if (cnt == ACQ_LAST) begin
            phase <= PH_CONV;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_CONV: begin
          if (cnt == CONV_LAST) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            irq_n <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: cnt <= '0;
      endcase
    end
  end
endmodule

// File: rtl/adc_sar_stub.sv
module adc_sar_stub #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic              done,
  input  logic [DATA_W-1:0] sample_word,
  output logic [DATA_W-1:0] result
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W - 1);

  logic [DATA_W-1:0] held;
  logic [DATA_W-1:0] approx;
  logic [DATA_W-1:0] trial;
  logic [IDX_W-1:0]  idx;

  assign trial = approx | (DATA_W'(1) << idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      held   <= '0;
      approx <= '0;
      idx    <= TOP_IDX;
      result <= '0;
    end else begin
      if (load) begin
        held   <= sample_word;
        approx <= '0;
        idx    <= TOP_IDX;
      end else if (step) begin
        if (trial <= held) approx <= trial;
        idx <= idx - 1'b1;
      end
      if (done) result <= approx;
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int ACQ_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [7:0]        din,
  input  logic [DATA_W-1:0] sar_word,
  output logic [1:0]        pwr_state,
  output logic              clk_ext,
  output logic              acq_ext,
  output logic              single_ended,
  output logic              unipolar,
  output logic [2:0]        chan_sel,
  output logic [DATA_W-1:0] result,
  output logic              irq_n,
  output logic              corrupt
);
  localparam int CONV_CYCLES = DATA_W + 1;

  logic   wr_commit, rd_access;
  pwr_t   pwr_q;
  phase_t phase;
  logic   sar_load, sar_step, conv_done;
  logic   cfg_match;

  adc_ctl_decode u_dec (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .din(din),
    .wr_commit(wr_commit), .rd_access(rd_access), .pwr_state(pwr_q),
    .clk_ext(clk_ext), .acq_ext(acq_ext), .single_ended(single_ended),
    .unipolar(unipolar), .chan_sel(chan_sel)
  );

  assign pwr_state = pwr_q;
  assign cfg_match = din[BIT_SGL:0] == {single_ended, unipolar, chan_sel};

  adc_phase_timer #(
    .DATA_W(DATA_W), .ACQ_CYCLES(ACQ_CYCLES), .CONV_CYCLES(CONV_CYCLES)
  ) u_tmr (
    .clk(clk), .rst(rst), .wr_commit(wr_commit), .rd_access(rd_access),
    .acqmod(din[BIT_ACQ]), .cfg_match(cfg_match), .phase(phase),
    .sar_load(sar_load), .sar_step(sar_step), .conv_done(conv_done),
    .irq_n(irq_n), .corrupt(corrupt)
  );

  adc_sar_stub #(.DATA_W(DATA_W)) u_sar (
    .clk(clk), .rst(rst), .load(sar_load), .step(sar_step), .done(conv_done),
    .sample_word(sar_word), .result(result)
  );
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_commit,
  input logic              rd_access,
  input logic              conv_done,
  input logic [1:0]        phase,
  input logic [1:0]        pwr_state,
  input logic              irq_n,
  input logic              corrupt,
  input logic [DATA_W-1:0] result
);
  assert_irq_after_write_R9: assert property (@(posedge clk) disable iff (rst)
    wr_commit |=> irq_n);

  assert_irq_after_read_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_access && !conv_done) |=> irq_n);

  assert_irq_falls_from_conv_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> $past(phase) == 2'b11);

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> $past(phase) == 2'b11 && !$past(wr_commit));

  assert_corrupt_from_write_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(corrupt) |-> $past(wr_commit));

  assert_wake_on_read_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_access && !wr_commit) |=> pwr_state == 2'b10);

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> irq_n && pwr_state == 2'b00 && !corrupt);
endmodule

bind adc_seq_ctrl adc_seq_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_commit(wr_commit), .rd_access(rd_access),
  .conv_done(conv_done), .phase(phase), .pwr_state(pwr_state),
  .irq_n(irq_n), .corrupt(corrupt), .result(result)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [7:0]  din = '0;
  logic [11:0] sar_word = '0;
  logic [1:0]  pwr_state;
  logic        clk_ext, acq_ext, single_ended, unipolar, irq_n, corrupt;
  logic [2:0]  chan_sel;
  logic [11:0] result;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  adc_seq_ctrl u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .din(din),
    .sar_word(sar_word), .pwr_state(pwr_state), .clk_ext(clk_ext),
    .acq_ext(acq_ext), .single_ended(single_ended), .unipolar(unipolar),
    .chan_sel(chan_sel), .result(result), .irq_n(irq_n), .corrupt(corrupt)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Returns at the negedge just after the commit edge.
  task automatic do_write(input logic [7:0] b);
    @(negedge clk); cs_n = 1'b0; din = b; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
  endtask

  task automatic do_read();
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk); rd_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic t_reset();
    check("R1 irq_n", irq_n, 1);
    check("R1 pwr_state", pwr_state, 0);
    check("R1 clk_ext", clk_ext, 0);
    check("R1 corrupt", corrupt, 0);
    check("R1 result", result, 0);
  endtask

  task automatic t_internal();
    sar_word = 12'hA5C;
    do_write(8'hDD);
    check("R2 pwr_state", pwr_state, 2);
    check("R2 clk_ext", clk_ext, 1);
    check("R2 acq_ext", acq_ext, 0);
    check("R2 single_ended", single_ended, 1);
    check("R2 unipolar", unipolar, 1);
    check("R2 chan_sel", chan_sel, 5);
    wait_n(15);
    check("R4 irq_n before 16", irq_n, 1);
    wait_n(1);
    check("R4 irq_n at 16", irq_n, 0);
    check("R6 result", result, 12'hA5C);
    do_read();
    check("R9 irq_n after read", irq_n, 1);
  endtask

  task automatic t_power();
    do_write(8'h40);
    check("R3 standby", pwr_state, 1);
    check("R3 clk_ext kept", clk_ext, 1);
    wait_n(20);
    do_read();
    check("R10 wake from standby", pwr_state, 2);
    check("R10 clk_ext kept", clk_ext, 1);
    do_write(8'h00);
    check("R3 full down", pwr_state, 0);
    check("R3 clk_ext kept full", clk_ext, 1);
    wait_n(20);
    do_read();
    check("R10 wake from full", pwr_state, 2);
    do_write(8'h98);
    check("R2 internal clock", clk_ext, 0);
    wait_n(20);
    do_read();
  endtask

  task automatic t_external();
    logic [11:0] prev;
    prev = result;
    sar_word = 12'h3F1;
    do_write(8'hB2);
    check("R2 acq_ext", acq_ext, 1);
    check("R2 chan_sel ext", chan_sel, 2);
    wait_n(40);
    check("R5 no conversion irq_n", irq_n, 1);
    check("R5 no conversion result", result, prev);
    sar_word = 12'h123;
    do_write(8'hD2);
    check("R8 PD change not corrupt", corrupt, 0);
    wait_n(12);
    check("R5 irq_n before 13", irq_n, 1);
    wait_n(1);
    check("R5 irq_n at 13", irq_n, 0);
    check("R6 result ext", result, 12'h123);
    check("R2 clk_ext ext", clk_ext, 1);
  endtask

  task automatic t_corrupt();
    do_write(8'hB2);
    check("R9 irq_n after write", irq_n, 1);
    sar_word = 12'h0F0;
    do_write(8'h93);
    check("R8 corrupt set", corrupt, 1);
    wait_n(13);
    check("R8 conv still ends", irq_n, 0);
    check("R6 result corrupt run", result, 12'h0F0);
    do_write(8'h98);
    check("R9 irq_n after write", irq_n, 1);
    check("R8 corrupt cleared", corrupt, 0);
    wait_n(20);
    do_read();
  endtask

  task automatic t_abort();
    logic [11:0] prev;
    prev = result;
    sar_word = 12'h777;
    do_write(8'h98);
    wait_n(8);
    sar_word = 12'h0AB;
    do_write(8'h98);
    check("R7 result kept on abort", result, prev);
    wait_n(15);
    check("R7 irq_n restart timing", irq_n, 1);
    check("R7 result kept", result, prev);
    wait_n(1);
    check("R7 irq_n after restart", irq_n, 0);
    check("R7 new result", result, 12'h0AB);
  endtask

  initial begin
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    t_reset();
    t_internal();
    t_power();
    t_external();
    t_corrupt();
    t_abort();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule